// File: doc/BRIEF.md
# Quadrant-Staged Tile Transpose Sequencer

This block moves one 8x8 tile of data words from a row-major source matrix into its transposed position in a row-major destination matrix. Both matrices sit in one shared single-port memory. A start pulse captures the two base byte addresses, the row pitch of each matrix in words, and the tile origin. The origin is a source row index and a source column index. The block then issues one word request at a time on a valid/ready port. It holds data in a small bank of eight scratch registers between the reads and the writes of each step.

The order of memory traffic is fixed and is the point of the block. Each step issues all of its reads before any of its writes. There are three phases, each run four times. In the staging phase, each source row of the upper half is split. Its left half goes straight to its final place. Its right half is parked, transposed, in the upper-right quadrant of the destination tile. In the swap phase, each parked row is read back together with one column of the source lower-left quadrant. The column goes to the upper-right quadrant, and the parked values go to the lower-left quadrant. In the corner phase, the lower-right quadrant is copied directly. With this order the source rows are consumed in a pattern that suits a direct-mapped cache downstream, and no extra buffer memory is needed.

Top module: `tile_xpose_seq`

## Requirements
- R1: When idle, a start pulse latches base_a, base_b, pitch_a, pitch_b, org_row (i) and org_col (j). busy is high in the next cycle, and the first request presented is a read (req_we=0) of source element (i, j).
- R2: The accepted requests follow this exact order of 160 operations, with k stepping 0..3 inside each phase. Staging: read S[i+k][j+0..7], then write those eight values to D[j+0..3][i+k] and to D[j+0..3][i+k+4]. Swap: read D[j+k][i+4..7], read S[i+4..7][j+k], write the column values to D[j+k][i+4..7], then write the parked values to D[j+4+k][i+0..3]. Corner: read S[i+4+k][j+4..7] and write them to D[j+4..7][i+4+k].
- R3: At most one request is outstanding. Read data is taken from rsp_rdata exactly one cycle after the read is accepted, and no request is presented in that cycle.
- R4: While req_valid is high and req_ready is low, req_addr, req_we and req_wdata stay unchanged and req_valid stays high.
- R5: At completion, D[j+q][i+p] equals S[i+p][j+q] for every p and q in 0..7.
- R6: One tile costs exactly 64 reads of the source, 16 reads of the destination and 80 writes to the destination. No destination word outside the tile is written.
- R7: done is high for exactly one cycle, in the cycle right after the final write is accepted. busy is low in that same cycle.
- R8: A start pulse while busy is ignored. The latched configuration and the running sequence are unchanged.
- R9: After reset, busy, done and req_valid are low.
- R10: Source element (r, c) is at byte address base_a + 4*(r*pitch_a + c). Destination element at row r, column c is at base_b + 4*(r*pitch_b + c). The two pitches are independent and may differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one tile move; ignored while busy |
| base_a | input | ADDR_W | Source matrix byte base address |
| base_b | input | ADDR_W | Destination matrix byte base address |
| pitch_a | input | PITCH_W | Source row length in words |
| pitch_b | input | PITCH_W | Destination row length in words |
| org_row | input | PITCH_W | Source row of the tile origin (i) |
| org_col | input | PITCH_W | Source column of the tile origin (j) |
| busy | output | 1 | Tile move in progress |
| done | output | 1 | One-cycle completion pulse |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts the request this cycle |
| req_we | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Byte address of the word |
| req_wdata | output | DATA_W | Write data |
| rsp_rdata | input | DATA_W | Read data, valid one cycle after read acceptance |

## Verification
The bench compares every accepted request with the full 160-step order. A design that issued a write before the reads of its step finished, or mixed up the parked quadrant with the lower-left column, would show up as a wrong address there, well before the final tile check. Non-square matrices with different pitches, and origins away from zero in both coordinates, would expose an address that used the wrong pitch or swapped i with j. Such a design would write outside the tile and damage the sentinel words. Random and heavy back-pressure targets requests that change while stalled, and read data taken a cycle early or late. A start pulse injected in the middle of a run catches a design that re-latches its configuration while busy.

// File: rtl/tile_xpose_pkg.sv
package tile_xpose_pkg;

   localparam int TILE_DIM   = 8;
   localparam int SLOT_COUNT = TILE_DIM;
   localparam int SLOT_W     = $clog2(SLOT_COUNT);
   localparam int OFF_W      = $clog2(TILE_DIM);

   typedef enum logic [1:0] {
      PH_STAGE  = 2'd0,
      PH_SWAP   = 2'd1,
      PH_CORNER = 2'd2
   } phase_e;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_ISSUE   = 2'd1,
      ST_CAPTURE = 2'd2
   } seq_state_e;

   typedef struct packed {
      logic              we;
      logic              to_dst;
      logic [SLOT_W-1:0] slot;
      logic [OFF_W-1:0]  roff;
      logic [OFF_W-1:0]  coff;
   } move_op_t;

endpackage

// File: rtl/tile_xpose_decode.sv
module tile_xpose_decode
   import tile_xpose_pkg::*;
(
   input  phase_e     phase,
   input  logic [1:0] step_k,
   input  logic [3:0] op_idx,
   output move_op_t   op
);

   always_comb begin
      op = '0;
      unique case (phase)
         PH_STAGE: begin
            if (!op_idx[3]) begin
               op.we     = 1'b0;
               op.to_dst = 1'b0;
               op.slot   = op_idx[2:0];
               op.roff   = {1'b0, step_k};
               op.coff   = op_idx[2:0];
            end else begin
               op.we     = 1'b1;
               op.to_dst = 1'b1;
               op.slot   = op_idx[2:0];
               op.roff   = {1'b0, op_idx[1:0]};
               op.coff   = {op_idx[2], step_k};
            end
         end
         PH_SWAP: begin
            unique case (op_idx[3:2])
               2'd0: begin
                  op.we = 1'b0; op.to_dst = 1'b1;
                  op.slot = {1'b0, op_idx[1:0]};
                  op.roff = {1'b0, step_k};
                  op.coff = {1'b1, op_idx[1:0]};
               end
               2'd1: begin
                  op.we = 1'b0; op.to_dst = 1'b0;
                  op.slot = {1'b1, op_idx[1:0]};
                  op.roff = {1'b1, op_idx[1:0]};
                  op.coff = {1'b0, step_k};
               end
               2'd2: begin
                  op.we = 1'b1; op.to_dst = 1'b1;
                  op.slot = {1'b1, op_idx[1:0]};
                  op.roff = {1'b0, step_k};
                  op.coff = {1'b1, op_idx[1:0]};
               end
               default: begin
                  op.we = 1'b1; op.to_dst = 1'b1;
                  op.slot = {1'b0, op_idx[1:0]};
                  op.roff = {1'b1, step_k};
                  op.coff = {1'b0, op_idx[1:0]};
               end
            endcase
         end
         PH_CORNER: begin
            if (!op_idx[2]) begin
               op.we = 1'b0; op.to_dst = 1'b0;
               op.slot = {1'b0, op_idx[1:0]};
               op.roff = {1'b1, step_k};
               op.coff = {1'b1, op_idx[1:0]};
            end else begin
               op.we = 1'b1; op.to_dst = 1'b1;
               op.slot = {1'b0, op_idx[1:0]};
               op.roff = {1'b1, op_idx[1:0]};
               op.coff = {1'b1, step_k};
            end
         end
         default: op = '0;
      endcase
   end

endmodule

// File: rtl/tile_xpose_agen.sv
module tile_xpose_agen
   import tile_xpose_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PITCH_W    = 16,
   parameter int WORD_BYTES = 4
) (
   input  move_op_t            op,
   input  logic [ADDR_W-1:0]   base_src,
   input  logic [ADDR_W-1:0]   base_dst,
   input  logic [PITCH_W-1:0]  pitch_src,
   input  logic [PITCH_W-1:0]  pitch_dst,
   input  logic [PITCH_W-1:0]  anchor_row,
   input  logic [PITCH_W-1:0]  anchor_col,
   output logic [ADDR_W-1:0]   addr
);

   localparam int BYTE_SH = $clog2(WORD_BYTES);

   if (PITCH_W > ADDR_W) begin : g_bad_pitch
      $error("tile_xpose_agen: PITCH_W must not exceed ADDR_W");
   end
   if ((1 << BYTE_SH) != WORD_BYTES) begin : g_bad_bytes
      $error("tile_xpose_agen: WORD_BYTES must be a power of two");
   end

   logic [ADDR_W-1:0] row_w, col_w, pitch_w, base_w, lin_w;

   // The source tile is anchored at (i, j); the destination tile at (j, i).
   always_comb begin
      if (op.to_dst) begin
         row_w   = ADDR_W'(anchor_col) + ADDR_W'(op.roff);
         col_w   = ADDR_W'(anchor_row) + ADDR_W'(op.coff);
         pitch_w = ADDR_W'(pitch_dst);
         base_w  = base_dst;
      end else begin
         row_w   = ADDR_W'(anchor_row) + ADDR_W'(op.roff);
         col_w   = ADDR_W'(anchor_col) + ADDR_W'(op.coff);
         pitch_w = ADDR_W'(pitch_src);
         base_w  = base_src;
      end
      lin_w = row_w * pitch_w + col_w;
      addr  = base_w + (lin_w << BYTE_SH);
   end

endmodule

// File: rtl/tile_xpose_scratch.sv
module tile_xpose_scratch
   import tile_xpose_pkg::*;
#(
   parameter int DATA_W         = 32,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] slot_q [SLOT_COUNT];

   for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q[s] <= '0;
            end else if (wr_en && (wr_slot == SLOT_W'(s))) begin
               slot_q[s] <= wr_data;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (wr_en && (wr_slot == SLOT_W'(s))) begin
               slot_q[s] <= wr_data;
            end
         end
      end
   end

   assign rd_data = slot_q[rd_slot];

endmodule

// File: rtl/tile_xpose_sched.sv
module tile_xpose_sched
   import tile_xpose_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       req_ready,
   input  logic       op_we,
   output phase_e     phase,
   output logic [1:0] step_k,
   output logic [3:0] op_idx,
   output logic       req_valid,
   output logic       cap_en,
   output logic       take_cfg,
   output logic       busy,
   output logic       done
);

   localparam logic [3:0] FULL_STEP_LAST   = 4'd15;
   localparam logic [3:0] CORNER_STEP_LAST = 4'd7;

   seq_state_e state_q;
   logic [3:0] step_last;
   logic       step_end, seq_end, advance, final_write;

   assign step_last   = (phase == PH_CORNER) ? CORNER_STEP_LAST : FULL_STEP_LAST;
   assign step_end    = (op_idx == step_last);
   assign seq_end     = step_end && (step_k == 2'd3) && (phase == PH_CORNER);
   assign req_valid   = (state_q == ST_ISSUE);
   assign cap_en      = (state_q == ST_CAPTURE);
   assign busy        = (state_q != ST_IDLE);
   assign take_cfg    = start && (state_q == ST_IDLE);
   assign final_write = req_valid && req_ready && op_we && seq_end;
   assign advance     = cap_en || (req_valid && req_ready && op_we && !seq_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done    <= 1'b0;
      end else begin
         done <= final_write;
         unique case (state_q)
            ST_IDLE:    if (start) state_q <= ST_ISSUE;
            ST_ISSUE: begin
               if (req_ready) begin
                  if (!op_we)          state_q <= ST_CAPTURE;
                  else if (seq_end)    state_q <= ST_IDLE;
               end
            end
            ST_CAPTURE: state_q <= ST_ISSUE;
            default:    state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_STAGE;
         step_k <= '0;
         op_idx <= '0;
      end else if (take_cfg) begin
         phase  <= PH_STAGE;
         step_k <= '0;
         op_idx <= '0;
      end else if (advance) begin
         if (step_end) begin
            op_idx <= '0;
            if (step_k == 2'd3) begin
               step_k <= '0;
               phase  <= (phase == PH_STAGE) ? PH_SWAP : PH_CORNER;
            end else begin
               step_k <= step_k + 2'd1;
            end
         end else begin
            op_idx <= op_idx + 4'd1;
         end
      end
   end

   AST_HOLD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(phase) && $stable(step_k) && $stable(op_idx)); // R4
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !op_we |=> !req_valid); // R3
   AST_CAPTURE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |-> $past(req_valid && req_ready && !op_we)); // R3
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(req_valid && req_ready && op_we) && !busy); // R7

endmodule

// File: rtl/tile_xpose_seq.sv
module tile_xpose_seq
   import tile_xpose_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int DATA_W         = 32,
   parameter int PITCH_W        = 16,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ADDR_W-1:0]  base_a,
   input  logic [ADDR_W-1:0]  base_b,
   input  logic [PITCH_W-1:0] pitch_a,
   input  logic [PITCH_W-1:0] pitch_b,
   input  logic [PITCH_W-1:0] org_row,
   input  logic [PITCH_W-1:0] org_col,
   output logic               busy,
   output logic               done,
   output logic               req_valid,
   input  logic               req_ready,
   output logic               req_we,
   output logic [ADDR_W-1:0]  req_addr,
   output logic [DATA_W-1:0]  req_wdata,
   input  logic [DATA_W-1:0]  rsp_rdata
);

   localparam int WORD_BYTES = DATA_W / 8;

   if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_data
      $error("tile_xpose_seq: DATA_W must be a whole number of bytes");
   end

   logic [ADDR_W-1:0]  base_a_q, base_b_q;
   logic [PITCH_W-1:0] pitch_a_q, pitch_b_q, org_row_q, org_col_q;
   phase_e             phase;
   logic [1:0]         step_k;
   logic [3:0]         op_idx;
   logic               cap_en, take_cfg;
   move_op_t           op;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_a_q  <= '0;
         base_b_q  <= '0;
         pitch_a_q <= '0;
         pitch_b_q <= '0;
         org_row_q <= '0;
         org_col_q <= '0;
      end else if (take_cfg) begin
         base_a_q  <= base_a;
         base_b_q  <= base_b;
         pitch_a_q <= pitch_a;
         pitch_b_q <= pitch_b;
         org_row_q <= org_row;
         org_col_q <= org_col;
      end
   end

   tile_xpose_sched i_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .req_ready (req_ready),
      .op_we     (op.we),
      .phase     (phase),
      .step_k    (step_k),
      .op_idx    (op_idx),
      .req_valid (req_valid),
      .cap_en    (cap_en),
      .take_cfg  (take_cfg),
      .busy      (busy),
      .done      (done)
   );

   tile_xpose_decode i_decode (
      .phase  (phase),
      .step_k (step_k),
      .op_idx (op_idx),
      .op     (op)
   );

   tile_xpose_agen #(
      .ADDR_W     (ADDR_W),
      .PITCH_W    (PITCH_W),
      .WORD_BYTES (WORD_BYTES)
   ) i_agen (
      .op         (op),
      .base_src   (base_a_q),
      .base_dst   (base_b_q),
      .pitch_src  (pitch_a_q),
      .pitch_dst  (pitch_b_q),
      .anchor_row (org_row_q),
      .anchor_col (org_col_q),
      .addr       (req_addr)
   );

   tile_xpose_scratch #(
      .DATA_W         (DATA_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) i_scratch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cap_en),
      .wr_slot (op.slot),
      .wr_data (rsp_rdata),
      .rd_slot (op.slot),
      .rd_data (req_wdata)
   );

   assign req_we = op.we;

   AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> $stable(req_addr) && $stable(req_we) && $stable(req_wdata)); // R4
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(base_a_q) && $stable(base_b_q) && $stable(org_row_q) && $stable(org_col_q)); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R7

endmodule

// File: tb/test_tile_xpose_seq.sv
module test_tile_xpose_seq;

   localparam int AW = 32;
   localparam int DW = 32;
   localparam int PW = 16;
   localparam logic [AW-1:0] BA = 32'h0000_0400;
   localparam logic [AW-1:0] BB = 32'h0000_2000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [AW-1:0] base_a = '0, base_b = '0;
   logic [PW-1:0] pitch_a = '0, pitch_b = '0, org_row = '0, org_col = '0;
   logic busy, done, req_valid, req_we;
   logic req_ready = 1'b1;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_wdata;
   logic [DW-1:0] rsp_rdata = '0;

   always #2.5 clk = ~clk;

   tile_xpose_seq i_tile_xpose_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .base_a(base_a), .base_b(base_b), .pitch_a(pitch_a), .pitch_b(pitch_b),
      .org_row(org_row), .org_col(org_col), .busy(busy), .done(done),
      .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata)
   );

   int n_tests = 0, n_fail = 0, cyc = 0;
   logic [DW-1:0] mem [0:4095];

   // configuration the bench expects the block to be working on
   int cm, cn, ci, cj, stall_mode;
   logic [15:0] lfsr = 16'hACE1;

   // monitor state
   int acc_n, seq_err, r3_err, r4_err, done_cnt, done_err, a_rd, b_rd, b_wr;
   bit prev_rd_acc, prev_wr_acc, prev_stall;
   logic [AW-1:0] hold_addr;
   logic hold_we;
   logic [DW-1:0] hold_wd;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] a_addr(input int r, input int c);
      return BA + AW'(4 * (r * cm + c));
   endfunction
   function automatic logic [AW-1:0] b_addr(input int r, input int c);
      return BB + AW'(4 * (r * cn + c));
   endfunction

   // expected {we, addr} of accepted request number n (R2, R10)
   function automatic logic [AW:0] exp_op(input int n);
      int k, x;
      if (n < 64) begin
         k = n / 16; x = n % 16;
         if (x < 8) return {1'b0, a_addr(ci + k, cj + x)};
         x = x - 8;
         return {1'b1, b_addr(cj + (x % 4), ci + k + ((x >= 4) ? 4 : 0))};
      end else if (n < 128) begin
         k = (n - 64) / 16; x = (n - 64) % 16;
         if (x < 4)  return {1'b0, b_addr(cj + k, ci + 4 + x)};
         if (x < 8)  return {1'b0, a_addr(ci + x, cj + k)};
         if (x < 12) return {1'b1, b_addr(cj + k, ci + x - 4)};
         return {1'b1, b_addr(cj + 4 + k, ci + x - 12)};
      end
      k = (n - 128) / 8; x = (n - 128) % 8;
      if (x < 4) return {1'b0, a_addr(ci + 4 + k, cj + 4 + x)};
      return {1'b1, b_addr(cj + x, ci + 4 + k)};
   endfunction

   always @(posedge clk) cyc <= cyc + 1;

   // memory model: single port, read data one cycle after acceptance
   always @(posedge clk) begin
      if (req_valid && req_ready) begin
         if (req_we) mem[req_addr[13:2]] <= req_wdata;
         else        rsp_rdata <= mem[req_addr[13:2]];
      end
   end

   // ready changes just after the edge
   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (stall_mode)
         0:       req_ready = 1'b1;
         1:       req_ready = lfsr[0];
         default: req_ready = lfsr[0] & lfsr[3];
      endcase
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_rd_acc && req_valid) r3_err++;
         if (prev_stall && (!req_valid || req_addr != hold_addr || req_we != hold_we ||
                            (req_we && req_wdata != hold_wd))) r4_err++;
         if (done) begin
            done_cnt++;
            if (!prev_wr_acc || busy) done_err++;
         end
         if (req_valid && req_ready) begin
            if ({req_we, req_addr} != exp_op(acc_n)) seq_err++;
            if (req_we) b_wr++;
            else if (req_addr < BB) a_rd++;
            else b_rd++;
            acc_n++;
         end
         prev_rd_acc = req_valid && req_ready && !req_we;
         prev_wr_acc = req_valid && req_ready && req_we;
         prev_stall  = req_valid && !req_ready;
         hold_addr = req_addr; hold_we = req_we; hold_wd = req_wdata;
      end
   end

   always @(posedge clk) begin
      if (cyc > 190000) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic run_tile(input int m, input int n, input int i, input int j,
                           input int mode, input bit restart, input int tag);
      int waitc;
      cm = m; cn = n; ci = i; cj = j; stall_mode = mode;
      for (int w = 0; w < 4096; w++) mem[w] = 32'h5E00_0000 | w;
      for (int w = 0; w < m * n; w++) mem[(BA >> 2) + w] = 32'hA000_0000 | (tag << 16) | w;
      acc_n = 0; seq_err = 0; r3_err = 0; r4_err = 0; done_cnt = 0; done_err = 0;
      a_rd = 0; b_rd = 0; b_wr = 0;
      @(negedge clk);
      base_a = BA; base_b = BB; pitch_a = PW'(m); pitch_b = PW'(n);
      org_row = PW'(i); org_col = PW'(j); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R1: busy next cycle, first request is read of source (i, j)
      chk(busy == 1'b1, "R1 busy after start", busy, 1);
      chk(req_valid && !req_we && req_addr == a_addr(i, j), "R1/R10 first request",
          req_addr, a_addr(i, j));
      base_a = 32'h0000_0800; base_b = 32'h0000_0100; org_row = 1; org_col = 2;
      if (restart) begin
         repeat (40) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         chk(busy == 1'b1, "R8 busy kept after stray start", busy, 1);
      end
      waitc = 0;
      while (done_cnt == 0 && waitc < 8000) begin
         @(negedge clk);
         waitc++;
      end
      repeat (4) @(negedge clk);
      chk(done_cnt == 1 && done_err == 0, "R7 single done after last write", done_cnt, 1);
      chk(!busy && !req_valid, "R7 idle after done", busy, 0);
      chk(seq_err == 0 && acc_n == 160, restart ? "R8 order unchanged by stray start" :
          "R2 request order", seq_err * 1000 + acc_n, 160);
      chk(r3_err == 0, "R3 no request in capture cycle", r3_err, 0);
      chk(r4_err == 0, "R4 request stable under stall", r4_err, 0);
      chk(a_rd == 64 && b_rd == 16 && b_wr == 80, "R6 access counts",
          a_rd * 10000 + b_rd * 100 + b_wr, 64 * 10000 + 16 * 100 + 80);
      begin
         int bad = 0;
         for (int p = 0; p < 8; p++)
            for (int q = 0; q < 8; q++)
               if (mem[b_addr(j + q, i + p) >> 2] != mem[a_addr(i + p, j + q) >> 2]) bad++;
         chk(bad == 0, "R5 tile transposed", bad, 0);
      end
      begin
         int bad = 0;
         for (int r = 0; r < m; r++)
            for (int c = 0; c < n; c++)
               if (!(r >= j && r < j + 8 && c >= i && c < i + 8) &&
                   mem[b_addr(r, c) >> 2] != (32'h5E00_0000 | (b_addr(r, c) >> 2))) bad++;
         chk(bad == 0, "R6 no write outside tile", bad, 0);
      end
   endtask

   initial begin
      stall_mode = 0;
      cm = 16; cn = 16; ci = 0; cj = 0;
      prev_rd_acc = 0; prev_wr_acc = 0; prev_stall = 0;
      repeat (3) @(negedge clk);
      chk(!busy, "R9 busy low in reset", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy, "R9 busy low after reset", busy, 0);
      chk(!done, "R9 done low after reset", done, 0);
      chk(!req_valid, "R9 req_valid low after reset", req_valid, 0);
      run_tile(16, 16, 0, 0, 0, 1'b0, 1);
      run_tile(16, 16, 8, 8, 1, 1'b0, 2);
      run_tile(16, 16, 8, 0, 2, 1'b0, 3);
      run_tile(12, 20, 12, 4, 1, 1'b0, 4); // R10 non-square, distinct pitches
      run_tile(20, 12, 4, 8, 0, 1'b0, 5);  // R10 other orientation
      run_tile(16, 16, 0, 8, 1, 1'b1, 6);  // R8 stray start mid-run
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule